// File: doc/BRIEF.md
# PSRAM Refresh Scheduler

This block sits on the host side of a pseudo-static RAM controller. It decides when the memory has to be refreshed. A free-running interval timer adds one owed refresh to a debt counter every `INTERVAL` clock cycles. While debt is owed, the block raises a refresh request toward the access sequencer. The sequencer answers with a grant, but only in a cycle between two accesses. Each grant starts a fixed refresh slot: the refresh strobe is active for `PULSE_CYC` cycles, followed by `GAP_CYC` recovery cycles. For the whole slot, `ref_busy` tells the sequencer not to start a chip-enable cycle. Requests that the sequencer cannot serve right away are not lost. They accumulate in the debt counter, which saturates at `DEBT_MAX`. Once the debt reaches `URGENT_TH`, an urgency flag tells the sequencer to put refresh ahead of pending accesses.

A low-power request moves the block into self-refresh. It waits until any refresh slot in progress has finished, then holds the strobe for at least `SR_MIN` cycles. After that it observes a recovery time of `SR_REC` cycles before the memory may be used again. The memory refreshes itself during this period, so the debt is cleared on entry. On exit, the debt is reloaded. In distributed mode it becomes a single refresh. In burst mode (`BURST_EXIT`) it becomes `BURST_N` refreshes, to be served back to back. In both modes the first post-exit refresh is flagged urgent, so it goes ahead of traffic and meets the hard deadline after wake-up. All timing constants are parameters counted in clock cycles.

Top module: `psram_refresh_sched`

## Requirements
- R1: While reset is asserted, and in the cycle after release, `ref_req`, `ref_urgent`, `ref_busy`, `rfsh_strobe` and `sr_busy` are all 0, and the owed count is 0.
- R2: Outside self-refresh, one refresh becomes owed every `INTERVAL` cycles. The first one becomes owed `INTERVAL` clock edges after reset release. `ref_req` is 1 exactly when the block is idle, `sleep_req` is 0 and the owed count is non-zero.
- R3: A grant is taken only in a cycle where `ref_req` and `ref_gnt` are both 1. That grant removes one owed refresh. `rfsh_strobe` then goes to 1 for exactly `PULSE_CYC` cycles, starting in the next cycle.
- R4: `ref_busy` is 1 for exactly `PULSE_CYC + GAP_CYC` cycles after a grant. No new request is raised during that time.
- R5: The owed count saturates at `DEBT_MAX` and changes by at most one per cycle outside self-refresh. After a long stretch without grants, exactly `DEBT_MAX` refreshes are served.
- R6: `ref_urgent` is 1 when a request is raised and the owed count is at least `URGENT_TH`, or when that request is the first one after a self-refresh exit.
- R7: A `sleep_req` that arrives while a refresh slot is running is deferred until the slot ends. Self-refresh (`sr_busy` = 1, `rfsh_strobe` = 1) starts in the cycle after the first idle cycle in which `sleep_req` is 1.
- R8: The self-refresh strobe stays active for at least `SR_MIN` cycles, even if `sleep_req` drops earlier. It stays active for exactly `SR_MIN` cycles if `sleep_req` is already low when that minimum ends.
- R9: After the strobe ends, `sr_busy` stays 1 with the strobe inactive for exactly `SR_REC` cycles.
- R10: On exit from self-refresh, the owed count becomes 1 in distributed mode (`BURST_EXIT` = 0) or `BURST_N` in burst mode (`BURST_EXIT` = 1), and the first request is raised as urgent.
- R11: During self-refresh, `ref_req` stays 0 and `ref_gnt` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req | input | 1 | Request to enter (1) or leave (0) self-refresh |
| ref_gnt | input | 1 | Sequencer grants a refresh slot (only between accesses) |
| ref_req | output | 1 | At least one refresh is owed and can be granted now |
| ref_urgent | output | 1 | Refresh must take priority over pending accesses |
| ref_busy | output | 1 | Refresh slot in progress; no chip-enable cycle may start |
| rfsh_strobe | output | 1 | Refresh strobe level toward the pin driver (1 = active) |
| sr_busy | output | 1 | Self-refresh or its recovery in progress |

## Verification
The bench goes after the following corner cases:
- Debt conservation under random grant patterns. A scheduler that lost a request when a tick coincided with a grant would under-refresh, and the count of refreshes served would fall behind the count owed.
- Saturation after a long starvation. A counter that wrapped instead of saturating would serve almost nothing.
- A sleep request landing mid-slot. A design that did not wait for the slot to end would cut the refresh strobe short.
- A sleep request that drops early. A design that did not enforce the minimum would leave self-refresh too soon.
- The post-exit reload in both modes. A wrong reload would miss the burst or the urgent first refresh after wake-up.

// File: rtl/psram_refresh_sched.sv
module psram_refresh_sched #(
  parameter int INTERVAL   = 3000,
  parameter int PULSE_CYC  = 20,
  parameter int GAP_CYC    = 20,
  parameter int SR_MIN     = 1700,
  parameter int SR_REC     = 130,
  parameter int DEBT_MAX   = 2048,
  parameter int URGENT_TH  = 4,
  parameter int BURST_N    = 2048,
  parameter bit BURST_EXIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic ref_gnt,
  output logic ref_req,
  output logic ref_urgent,
  output logic ref_busy,
  output logic rfsh_strobe,
  output logic sr_busy
);

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int CMAX = mx(mx(PULSE_CYC, GAP_CYC), mx(SR_MIN, SR_REC));
  localparam int CW   = $clog2(CMAX + 1);
  localparam int IW   = $clog2(INTERVAL + 1);
  localparam int DW   = $clog2(DEBT_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_PULSE, S_GAP, S_SR, S_REC} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [IW-1:0] itim;
  logic [DW-1:0] owed;
  logic          post_exit;

  wire idle    = (st == S_IDLE);
  wire in_sr   = (st == S_SR) || (st == S_REC);
  wire tick    = !in_sr && (itim == IW'(INTERVAL - 1));
  wire grant   = ref_req && ref_gnt;
  wire sr_exit = (st == S_REC) && (cnt == CW'(SR_REC - 1));

  assign ref_req     = idle && !sleep_req && (owed != '0);
  assign ref_urgent  = ref_req && (post_exit || (owed >= DW'(URGENT_TH)));
  assign ref_busy    = (st == S_PULSE) || (st == S_GAP);
  assign rfsh_strobe = (st == S_PULSE) || (st == S_SR);
  assign sr_busy     = in_sr;

  always_ff @(posedge clk) begin
    if (!rst_n)                itim <= '0;
    else if (in_sr || tick)    itim <= '0;
    else                       itim <= itim + IW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                owed <= '0;
    else if (st == S_SR)       owed <= '0;
    else if (sr_exit)          owed <= BURST_EXIT ? DW'(BURST_N) : DW'(1);
    else if (tick && !grant)   owed <= (owed == DW'(DEBT_MAX)) ? owed : owed + DW'(1);
    else if (grant && !tick)   owed <= owed - DW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      post_exit <= 1'b0;
    else if (sr_exit)                post_exit <= 1'b1;
    else if (grant || st == S_SR)    post_exit <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (sleep_req)  st <= S_SR;
          else if (grant) st <= S_PULSE;
        end
        S_PULSE: begin
          if (cnt == CW'(PULSE_CYC - 1)) begin
            st  <= S_GAP;
            cnt <= '0;
          end else cnt <= cnt + CW'(1);
        end
        S_GAP: begin
          if (cnt == CW'(GAP_CYC - 1)) begin
            st  <= S_IDLE;
            cnt <= '0;
          end else cnt <= cnt + CW'(1);
        end
        S_SR: begin
          if (cnt == CW'(SR_MIN - 1)) begin
            if (!sleep_req) begin
              st  <= S_REC;
              cnt <= '0;
            end
          end else cnt <= cnt + CW'(1);
        end
        S_REC: begin
          if (sr_exit) begin
            st  <= S_IDLE;
            cnt <= '0;
          end else cnt <= cnt + CW'(1);
        end
        default: begin
          st  <= S_IDLE;
          cnt <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/psram_refresh_sched_chk.sv
module psram_refresh_sched_chk #(
  parameter int DEBT_MAX = 2048,
  parameter int DW       = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sleep_req,
  input logic          ref_gnt,
  input logic          ref_req,
  input logic          ref_urgent,
  input logic          ref_busy,
  input logic          rfsh_strobe,
  input logic          sr_busy,
  input logic [DW-1:0] owed
);

  a_r3_slot_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_busy) |-> $past(ref_req && ref_gnt));

  a_r3_strobe_owned: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_strobe |-> (ref_busy || sr_busy));

  a_r5_debt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(owed) <= DEBT_MAX);

  a_r5_debt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!sr_busy && $past(!sr_busy)) |->
      (int'(owed) == int'($past(owed)) || int'(owed) == int'($past(owed)) + 1 ||
       int'(owed) + 1 == int'($past(owed))));

  a_r8_sr_starts_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_busy) |-> rfsh_strobe);

  a_r11_sr_needs_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_busy) |-> $past(sleep_req));

  a_r10_exit_urgent: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sr_busy) && !sleep_req) |-> ref_urgent);

endmodule

bind psram_refresh_sched psram_refresh_sched_chk #(.DEBT_MAX(DEBT_MAX), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .ref_gnt(ref_gnt),
  .ref_req(ref_req), .ref_urgent(ref_urgent), .ref_busy(ref_busy),
  .rfsh_strobe(rfsh_strobe), .sr_busy(sr_busy), .owed(owed)
);

// File: tb/test_psram_refresh_sched.sv
`timescale 1ns/1ps
module test_psram_refresh_sched;
  localparam int INTERVAL = 50, PULSE = 3, GAP = 2, SRMIN = 20, SRREC = 6;
  localparam int DMAX = 7, TH = 3, BURST = 5;

  logic clk = 1'b0, rst_n = 1'b0, sleep_req = 1'b0, ref_gnt = 1'b0;
  logic req_b, urg_b, busy_b, stb_b, sr_b;
  logic req_d, urg_d, busy_d, stb_d, sr_d;

  psram_refresh_sched #(.INTERVAL(INTERVAL), .PULSE_CYC(PULSE), .GAP_CYC(GAP),
    .SR_MIN(SRMIN), .SR_REC(SRREC), .DEBT_MAX(DMAX), .URGENT_TH(TH),
    .BURST_N(BURST), .BURST_EXIT(1'b1)) i_psram_refresh_sched (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .ref_gnt(ref_gnt),
    .ref_req(req_b), .ref_urgent(urg_b), .ref_busy(busy_b),
    .rfsh_strobe(stb_b), .sr_busy(sr_b));

  psram_refresh_sched #(.INTERVAL(INTERVAL), .PULSE_CYC(PULSE), .GAP_CYC(GAP),
    .SR_MIN(SRMIN), .SR_REC(SRREC), .DEBT_MAX(DMAX), .URGENT_TH(TH),
    .BURST_N(BURST), .BURST_EXIT(1'b0)) i_dist (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .ref_gnt(ref_gnt),
    .ref_req(req_d), .ref_urgent(urg_d), .ref_busy(busy_d),
    .rfsh_strobe(stb_d), .sr_busy(sr_d));

  always #2.5 clk = ~clk;

  int edges = 0;
  always @(posedge clk) edges <= rst_n ? edges + 1 : 0;

  int checks = 0, fails = 0, grants = 0, grants_d = 0, left = 0;
  bit model_on = 1'b0;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at edge %0d", r, act, exp, edges);
    end
  endtask

  function automatic int owed_exp();
    return edges / INTERVAL - grants;
  endfunction

  task automatic step(input bit g, input bit s);
    bit er;
    @(negedge clk);
    ref_gnt = g;
    sleep_req = s;
    #1;
    if (model_on) begin
      er = (left == 0) && !s && owed_exp() > 0;
      chk(busy_b == (left > 0), "R4", busy_b, left > 0);
      chk(stb_b == (left > GAP), "R3", stb_b, left > GAP);
      chk(req_b == er, "R2", req_b, er);
      chk(urg_b == (er && owed_exp() >= TH), "R6", urg_b, er && owed_exp() >= TH);
    end
    if (left > 0) left--;
    if (req_b && g) begin
      grants++;
      left = PULSE + GAP;
    end
    if (req_d && g) grants_d++;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sleep_req = 1'b0; ref_gnt = 1'b0;
    grants = 0; grants_d = 0; left = 0;
    repeat (3) @(negedge clk);
    #1;
    chk({req_b, urg_b, busy_b, stb_b, sr_b} == 5'b0, "R1",
        int'({req_b, urg_b, busy_b, stb_b, sr_b}), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int sc, rc, nb, nd;
    void'($urandom(32'd2024));

    // R1/R2: quiet after reset, first request after INTERVAL edges
    do_reset();
    model_on = 1'b1;
    step(0, 0);
    chk(req_b == 1'b0, "R1", req_b, 0);
    while (edges < INTERVAL) step(0, 0);
    chk(req_b == 1'b1, "R2", req_b, 1);

    // R2/R3/R4/R6: random grants checked against owed model
    for (int i = 0; i < 4000; i++) step(($urandom % 100) < 22, 0);
    repeat (60) step(1, 0);
    chk(owed_exp() >= 0 && owed_exp() <= 1, "R2", owed_exp(), 0);
    model_on = 1'b0;

    // R5/R6: saturation after starvation
    do_reset();
    while (edges < (DMAX + 3) * INTERVAL) step(0, 0);
    step(0, 0);
    chk(urg_b == 1'b1, "R6", urg_b, 1);
    nb = grants;
    repeat (45) step(1, 0);
    chk(grants - nb == DMAX, "R5", grants - nb, DMAX);
    chk(req_b == 1'b0, "R5", req_b, 0);

    // R7: sleep deferred behind a running slot
    do_reset();
    while (edges < INTERVAL) step(0, 0);
    step(1, 0);
    chk(left == PULSE + GAP, "R3", left, PULSE + GAP);
    for (int i = 0; i < PULSE + GAP + 1; i++) begin
      step(0, 1);
      chk(sr_b == 1'b0, "R7", sr_b, 0);
    end
    step(0, 1);
    chk(sr_b && stb_b, "R7", int'({sr_b, stb_b}), 3);

    // R8/R11: early drop of sleep, grants ignored
    sc = 1;
    for (int i = 0; i < 4; i++) begin
      step(1, 1);
      if (stb_b) sc++;
      chk(req_b == 1'b0 && req_d == 1'b0, "R11", req_b, 0);
    end
    for (int i = 0; i < 200 && stb_b; i++) begin
      step(1, 0);
      if (stb_b) sc++;
      chk(busy_b == 1'b0, "R11", busy_b, 0);
    end
    chk(sc == SRMIN, "R8", sc, SRMIN);

    // R9/R10: recovery, then reload and urgency
    nb = grants; nd = grants_d;
    rc = 1;
    for (int i = 0; i < 200 && sr_b; i++) begin
      step(1, 0);
      if (sr_b) begin
        rc++;
        chk(stb_b == 1'b0, "R9", stb_b, 0);
      end
    end
    chk(rc == SRREC, "R9", rc, SRREC);
    chk(urg_b == 1'b1, "R10", urg_b, 1);
    chk(urg_d == 1'b1, "R10", urg_d, 1);
    repeat (40) step(1, 0);
    chk(grants - nb == BURST, "R10", grants - nb, BURST);
    chk(grants_d - nd == 1, "R10", grants_d - nd, 1);
    chk(req_b == 1'b0 && req_d == 1'b0, "R10", int'({req_b, req_d}), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule